// File: doc/BRIEF.md
# Password-Gated Debug Access Controller

This block decides whether privileged debug and in-system programming operations may touch a program memory. It keeps two lock bits. The password lock is set at power-on. It clears only when a debug host presents a sequence of candidate words that equals the password held in program memory. The code lock is non-volatile and absolute. While it is set, no password unlocks the part, and only a mass erase clears it. Access is granted only while both locks are clear.

A host opens an attempt with a request strobe. It then supplies the candidate words one at a time. For each word, the controller reads the matching stored word through a one-cycle-latency read port and compares the two. The stored password occupies the sixteen words at addresses 0x10 to 0x1F. Candidate word i is compared against address 0x10+i, in ascending order. The first mismatch ends the attempt. A mass-erase command clears the code lock and emits a one-cycle erase pulse to the memory. The erased memory then holds zeros, so all-zero candidates unlock it. The code lock is kept in non-volatile storage outside this block. It is reloaded from the `cl_restore_i` input at power-on reset.

States: IDLE (waiting for a request), COLLECT (waiting for the next candidate word), CHECK (comparing the read-back word), PASS (one-cycle success), FAIL (one-cycle rejection). The transitions are as follows:
- IDLE→COLLECT on a request while the code lock is clear.
- IDLE→FAIL on a request while the code lock is set.
- COLLECT→CHECK when a candidate word arrives.
- CHECK→COLLECT on a match that is not the last word.
- CHECK→PASS on a match of the last word.
- CHECK→FAIL on a mismatch.
- PASS→IDLE and FAIL→IDLE unconditionally.
- COLLECT or CHECK→IDLE on a lock command, an erase command or an ordinary reset.

Top module: `pwgate_top`

## Requirements
- R1: While `por_n_i` is low at a clock edge, the password lock becomes 1, the code lock takes the value of `cl_restore_i`, and the sequencer returns to IDLE (`busy_o` = 0).
- R2: `grant_o` is 1 exactly when both the password lock and the code lock are 0.
- R3: In an attempt, the read issued for candidate word i (i = 0..15) uses address 0x10+i. A read is issued in the cycle the word is presented, and the stored word is compared one cycle later.
- R4: When all sixteen words match, `pass_o` is high for one cycle, and the password lock is 0 in that same cycle.
- R5: On the first mismatching word, `fail_o` is high for one cycle, the attempt ends, later words cause no reads, and the password lock keeps its value.
- R6: Once cleared, the password lock stays 0 through ordinary resets (`rst_n_i`). Only a power-on reset sets it again.
- R7: `lock_cmd_i` sets the code lock, and the code lock survives ordinary reset.
- R8: While the code lock is set, a request yields a one-cycle `fail_o` with no memory reads, even with the correct password, and the password lock stays unchanged.
- R9: `erase_cmd_i` clears the code lock at the next edge and drives `erase_go_o` high for the following cycle. It takes priority over `lock_cmd_i` in the same cycle. Afterwards, an all-zero password unlocks.
- R10: An ordinary reset, a lock command or an erase command aborts an attempt in progress. The attempt returns to IDLE, and words presented afterwards cause no reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, synchronous |
| rst_n_i | input | 1 | Ordinary reset, active low, synchronous; keeps lock bits |
| cl_restore_i | input | 1 | Non-volatile code lock value loaded at power-on |
| unlock_req_i | input | 1 | Starts a password attempt |
| cand_valid_i | input | 1 | Candidate word strobe |
| cand_word_i | input | WORD_W | Candidate password word |
| mem_rd_en_o | output | 1 | Program memory read enable |
| mem_addr_o | output | ADDR_W | Program memory word address |
| mem_rd_data_i | input | WORD_W | Read data, valid one cycle after the read |
| lock_cmd_i | input | 1 | Sets the code lock |
| erase_cmd_i | input | 1 | Mass-erase command |
| erase_go_o | output | 1 | One-cycle erase pulse to the memory |
| busy_o | output | 1 | Attempt in progress (COLLECT or CHECK) |
| pass_o | output | 1 | Attempt succeeded (PASS state) |
| fail_o | output | 1 | Attempt rejected (FAIL state) |
| grant_o | output | 1 | Privileged access allowed |
| pwd_lock_o | output | 1 | Password lock bit |
| code_lock_o | output | 1 | Code lock bit |

## Verification
The assertions assume that read data arrives exactly one cycle after a read and that the memory holds still while an attempt runs. They also assume that `cl_restore_i` is steady while `por_n_i` is low. The stimulus respects these assumptions. The bench memory model answers every read on the next edge and zeroes its contents only on `erase_go_o`, never during an attempt. The restore input is changed only in the same half-cycle that power-on reset is asserted. All command and candidate inputs change on the falling clock edge, so the block always sees single-cycle strobes that are stable around the rising edge.

// File: rtl/pwgate_pkg.sv
package pwgate_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_CHECK   = 3'd2,
        ST_PASS    = 3'd3,
        ST_FAIL    = 3'd4
    } pg_state_t;
endpackage

// File: rtl/pwgate_seq.sv
module pwgate_seq
    import pwgate_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 10,
    parameter int PW_BASE = 16,
    parameter int PW_LEN  = 16
) (
    input  logic              clk_i,
    input  logic              por_n_i,
    input  logic              rst_n_i,
    input  logic              start_i,
    input  logic              code_locked_i,
    input  logic              abort_i,
    input  logic              cand_valid_i,
    input  logic [WORD_W-1:0] cand_word_i,
    input  logic [WORD_W-1:0] mem_rd_data_i,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              unlock_evt_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic              busy_o
);
    localparam int IDX_W = (PW_LEN > 1) ? $clog2(PW_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PW_LEN - 1);

    pg_state_t         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] cand_q;
    logic              sys_rst_n;
    logic              word_match;

    assign sys_rst_n  = por_n_i & rst_n_i;
    assign word_match = (cand_q == mem_rd_data_i);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && !abort_i)
                    state_d = code_locked_i ? ST_FAIL : ST_COLLECT;
            end
            ST_COLLECT: begin
                if (abort_i)           state_d = ST_IDLE;
                else if (cand_valid_i) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (abort_i)          state_d = ST_IDLE;
                else if (!word_match) state_d = ST_FAIL;
                else if (idx_q == LAST_IDX) state_d = ST_PASS;
                else                  state_d = ST_COLLECT;
            end
            ST_PASS: state_d = ST_IDLE;
            ST_FAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register plus word index and captured candidate
    always_ff @(posedge clk_i) begin
        if (!sys_rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cand_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                idx_q <= '0;
            else if (state_q == ST_CHECK && state_d == ST_COLLECT)
                idx_q <= idx_q + 1'b1;
            if (state_q == ST_COLLECT && cand_valid_i)
                cand_q <= cand_word_i;
        end
    end

    // outputs
    always_comb begin
        mem_rd_en_o  = (state_q == ST_COLLECT) && cand_valid_i && !abort_i;
        mem_addr_o   = ADDR_W'(PW_BASE) + ADDR_W'(idx_q);
        unlock_evt_o = (state_q == ST_CHECK) && (state_d == ST_PASS);
        pass_o       = (state_q == ST_PASS);
        fail_o       = (state_q == ST_FAIL);
        busy_o       = (state_q == ST_COLLECT) || (state_q == ST_CHECK);
    end

    AST_READ_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
        mem_rd_en_o |-> (mem_addr_o >= ADDR_W'(PW_BASE)) &&
                        (mem_addr_o <  ADDR_W'(PW_BASE + PW_LEN))); // R3
    AST_RESULT_RETURNS_IDLE: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
        (pass_o || fail_o) |=> !busy_o && !pass_o && !fail_o); // R5
    AST_ABORT_ENDS_ATTEMPT: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
        (busy_o && abort_i) |=> !busy_o && !pass_o); // R10
endmodule

// File: rtl/pwgate_locks.sv
module pwgate_locks (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic rst_n_i,
    input  logic cl_restore_i,
    input  logic unlock_evt_i,
    input  logic lock_cmd_i,
    input  logic erase_cmd_i,
    output logic pwd_lock_o,
    output logic code_lock_o,
    output logic erase_go_o
);
    logic pwd_lock_q, code_lock_q, erase_go_q;

    // lock bits: only power-on reset touches them
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            pwd_lock_q  <= 1'b1;
            code_lock_q <= cl_restore_i;
        end else begin
            if (unlock_evt_i)     pwd_lock_q  <= 1'b0;
            if (erase_cmd_i)      code_lock_q <= 1'b0;
            else if (lock_cmd_i)  code_lock_q <= 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!por_n_i || !rst_n_i) erase_go_q <= 1'b0;
        else                      erase_go_q <= erase_cmd_i;
    end

    assign pwd_lock_o  = pwd_lock_q;
    assign code_lock_o = code_lock_q;
    assign erase_go_o  = erase_go_q;

    AST_PW_NO_RELOCK: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !$rose(pwd_lock_q)); // R6
    AST_CL_ONLY_ERASE: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(code_lock_q) |-> $past(erase_cmd_i)); // R9
    AST_CL_SET_BY_CMD: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(code_lock_q) |-> $past(lock_cmd_i) && !$past(erase_cmd_i)); // R7
endmodule

// File: rtl/pwgate_top.sv
module pwgate_top #(
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 10,
    parameter int PW_BASE = 16,
    parameter int PW_LEN  = 16
) (
    input  logic              clk_i,
    input  logic              por_n_i,
    input  logic              rst_n_i,
    input  logic              cl_restore_i,
    input  logic              unlock_req_i,
    input  logic              cand_valid_i,
    input  logic [WORD_W-1:0] cand_word_i,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_rd_data_i,
    input  logic              lock_cmd_i,
    input  logic              erase_cmd_i,
    output logic              erase_go_o,
    output logic              busy_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic              grant_o,
    output logic              pwd_lock_o,
    output logic              code_lock_o
);
    logic unlock_evt;
    logic abort;

    assign abort = erase_cmd_i | lock_cmd_i;

    pwgate_seq #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .PW_BASE(PW_BASE),
        .PW_LEN (PW_LEN)
    ) seq_i (
        .clk_i        (clk_i),
        .por_n_i      (por_n_i),
        .rst_n_i      (rst_n_i),
        .start_i      (unlock_req_i),
        .code_locked_i(code_lock_o),
        .abort_i      (abort),
        .cand_valid_i (cand_valid_i),
        .cand_word_i  (cand_word_i),
        .mem_rd_data_i(mem_rd_data_i),
        .mem_rd_en_o  (mem_rd_en_o),
        .mem_addr_o   (mem_addr_o),
        .unlock_evt_o (unlock_evt),
        .pass_o       (pass_o),
        .fail_o       (fail_o),
        .busy_o       (busy_o)
    );

    pwgate_locks locks_i (
        .clk_i       (clk_i),
        .por_n_i     (por_n_i),
        .rst_n_i     (rst_n_i),
        .cl_restore_i(cl_restore_i),
        .unlock_evt_i(unlock_evt),
        .lock_cmd_i  (lock_cmd_i),
        .erase_cmd_i (erase_cmd_i),
        .pwd_lock_o  (pwd_lock_o),
        .code_lock_o (code_lock_o),
        .erase_go_o  (erase_go_o)
    );

    assign grant_o = !pwd_lock_o && !code_lock_o;

    AST_PASS_UNLOCKED: assert property (@(posedge clk_i) disable iff (!por_n_i || !rst_n_i)
        pass_o |-> !pwd_lock_o && grant_o == !code_lock_o); // R4
    AST_LOCKED_NO_READ: assert property (@(posedge clk_i) disable iff (!por_n_i || !rst_n_i)
        code_lock_o |-> !mem_rd_en_o && !pass_o); // R8
    AST_FAIL_KEEPS_LOCK: assert property (@(posedge clk_i) disable iff (!por_n_i || !rst_n_i)
        fail_o |-> $stable(pwd_lock_o)); // R5
    AST_GRANT_NEEDS_PASS: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(grant_o) |-> $past(unlock_evt) || $past(erase_cmd_i)); // R2
endmodule

// File: tb/pwgate_top_tb_top.sv
module pwgate_top_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b1, cl_restore = 1'b0;
    logic        req = 1'b0, valid = 1'b0, lock_cmd = 1'b0, erase_cmd = 1'b0;
    logic [15:0] word = '0, rdata = '0;
    logic        rd_en, erase_go, busy, pass_w, fail_w, grant, pwd_lock, code_lock;
    logic [9:0]  addr;

    int errors = 0, checks = 0;
    int pass_cnt = 0, fail_cnt = 0, rd_cnt = 0, addr_err = 0;
    logic [15:0] mem [16];

    always #2 clk = ~clk;

    pwgate_top dut_i (
        .clk_i(clk), .por_n_i(por_n), .rst_n_i(rst_n), .cl_restore_i(cl_restore),
        .unlock_req_i(req), .cand_valid_i(valid), .cand_word_i(word),
        .mem_rd_en_o(rd_en), .mem_addr_o(addr), .mem_rd_data_i(rdata),
        .lock_cmd_i(lock_cmd), .erase_cmd_i(erase_cmd), .erase_go_o(erase_go),
        .busy_o(busy), .pass_o(pass_w), .fail_o(fail_w), .grant_o(grant),
        .pwd_lock_o(pwd_lock), .code_lock_o(code_lock)
    );

    function automatic logic [15:0] pw(input int i);
        return 16'(32'h5A3C + i * 32'h0F11);
    endfunction

    // memory model: one-cycle read latency, zeroed by erase pulse
    always @(posedge clk) begin
        if (erase_go) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else if (rd_en) begin
            rdata <= (addr >= 10'd16 && addr < 10'd32) ? mem[addr[3:0]] : 16'hFFFF;
        end
    end

    // monitor, sampled away from the rising edge
    always @(negedge clk) begin
        #1;
        if (pass_w) pass_cnt++;
        if (fail_w) fail_cnt++;
        if (rd_en) begin
            if (addr != 10'(16 + rd_cnt)) addr_err++;
            rd_cnt++;
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic clr();
        pass_cnt = 0; fail_cnt = 0; rd_cnt = 0; addr_err = 0;
    endtask

    task automatic por_pulse(input logic rest);
        @(negedge clk); por_n = 1'b0; cl_restore = rest;
        @(negedge clk); @(negedge clk); por_n = 1'b1;
        @(negedge clk); #2;
    endtask

    task automatic attempt(input int bad, input bit zero);
        clr();
        @(negedge clk); req = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); req = 1'b0; valid = 1'b1;
            word = (zero ? 16'h0 : pw(i)) ^ ((i == bad) ? 16'h0001 : 16'h0);
            @(negedge clk); valid = 1'b0;
        end
        repeat (3) @(negedge clk);
        #2;
    endtask

    // vector: {expect pass, corrupted word index (16 = none)}
    localparam logic [5:0] VEC [5] = '{
        {1'b1, 5'd16}, {1'b0, 5'd0}, {1'b0, 5'd7}, {1'b0, 5'd15}, {1'b1, 5'd16}
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = pw(i);
        por_pulse(1'b0);
        // R1 reset state, R2 grant
        check(pwd_lock == 1'b1, "R1 pwd lock", pwd_lock, 1);
        check(code_lock == 1'b0, "R1 code lock", code_lock, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(grant == 1'b0, "R2 grant locked", grant, 0);

        foreach (VEC[v]) begin
            int bad_i;
            bit exp_pass;
            int exp_rd;
            bad_i = int'(VEC[v][4:0]);
            exp_pass = VEC[v][5];
            exp_rd = exp_pass ? 16 : bad_i + 1;
            por_pulse(1'b0);
            attempt(bad_i, 1'b0);
            check(pass_cnt == (exp_pass ? 1 : 0), "R4 pass pulse", pass_cnt, exp_pass ? 1 : 0);
            check(fail_cnt == (exp_pass ? 0 : 1), "R5 fail pulse", fail_cnt, exp_pass ? 0 : 1);
            check(rd_cnt == exp_rd, "R5 read count", rd_cnt, exp_rd);
            check(addr_err == 0, "R3 read address order", addr_err, 0);
            check(pwd_lock == !exp_pass, "R4 pwd lock", pwd_lock, !exp_pass);
            check(grant == exp_pass, "R2 grant", grant, exp_pass);
        end

        // R6: ordinary reset keeps the cleared password lock
        @(negedge clk); rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #2;
        check(pwd_lock == 1'b0, "R6 pwd lock after rst", pwd_lock, 0);
        check(grant == 1'b1, "R6 grant after rst", grant, 1);

        // R7: lock command, survives ordinary reset
        @(negedge clk); lock_cmd = 1'b1; @(negedge clk); lock_cmd = 1'b0; #2;
        check(code_lock == 1'b1, "R7 code lock set", code_lock, 1);
        check(grant == 1'b0, "R2 grant with code lock", grant, 0);
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk); #2;
        check(code_lock == 1'b1, "R7 code lock after rst", code_lock, 1);

        // R1/R8: power-on reload of the lock, correct password refused
        por_pulse(1'b1);
        check(code_lock == 1'b1, "R1 code lock restored", code_lock, 1);
        check(pwd_lock == 1'b1, "R1 pwd lock set", pwd_lock, 1);
        attempt(16, 1'b0);
        check(fail_cnt == 1, "R8 fail when code locked", fail_cnt, 1);
        check(rd_cnt == 0, "R8 no reads", rd_cnt, 0);
        check(pass_cnt == 0, "R8 no pass", pass_cnt, 0);
        check(pwd_lock == 1'b1, "R8 pwd lock kept", pwd_lock, 1);

        // R9: erase clears code lock, pulses, zero password unlocks
        @(negedge clk); erase_cmd = 1'b1; @(negedge clk); erase_cmd = 1'b0; #2;
        check(erase_go == 1'b1, "R9 erase pulse", erase_go, 1);
        check(code_lock == 1'b0, "R9 code lock cleared", code_lock, 0);
        @(negedge clk); #2;
        check(erase_go == 1'b0, "R9 erase pulse ends", erase_go, 0);
        attempt(16, 1'b1);
        check(pass_cnt == 1, "R9 zero password pass", pass_cnt, 1);
        check(pwd_lock == 1'b0, "R9 pwd lock cleared", pwd_lock, 0);

        // R10: ordinary reset aborts an attempt midway
        por_pulse(1'b0);
        clr();
        @(negedge clk); req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); req = 1'b0; valid = 1'b1; word = 16'h0;
            @(negedge clk); valid = 1'b0;
        end
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; #2;
        check(busy == 1'b0, "R10 busy after abort", busy, 0);
        for (int i = 3; i < 16; i++) begin
            @(negedge clk); valid = 1'b1; word = 16'h0;
            @(negedge clk); valid = 1'b0;
        end
        repeat (2) @(negedge clk); #2;
        check(rd_cnt == 3, "R10 no reads after abort", rd_cnt, 3);
        check(pwd_lock == 1'b1, "R10 pwd lock kept", pwd_lock, 1);

        // R9: erase wins over lock in the same cycle
        @(negedge clk); erase_cmd = 1'b1; lock_cmd = 1'b1;
        @(negedge clk); erase_cmd = 1'b0; lock_cmd = 1'b0; #2;
        check(code_lock == 1'b0, "R9 erase priority", code_lock, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule